// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator

This block raises a stream of 14-bit samples to twice its rate. It runs on a single clock at the output rate. It asks for one new input sample every second cycle through a take strobe, and it returns one output sample on every cycle. The filter is a 43-tap linear-phase half-band FIR in polyphase form. One output of each pair is the input sample delayed by eleven input periods. The other is the value halfway between two inputs, formed from eleven folded coefficient pairs. Data enters and leaves in straight binary, where 0x2000 is midscale.

A mode input turns the default low-pass response into a high-pass one. It does this by mixing with a tone at half the output rate: every interpolated (odd) output sample is negated about midscale. This keeps the upper image and suppresses baseband. The mode is sampled only at the start of an output pair, so a pair never mixes the two responses. Arithmetic runs at full precision. Results are rounded half up to 14 bits and clamped to the code range.

Top module: `hb2x_interp`

## Requirements
- R1: While `rst` is high at a rising edge, the block loads midscale into its sample history and sets `dout` to 0x2000 and `dout_odd` to 0. The first cycle after reset has `take_in` high.
- R2: `take_in` is high on alternate cycles. `din` is captured only at a rising edge where `take_in` is high. Its value in other cycles has no effect on any output.
- R3: The edge that captures a sample registers an interpolated output with `dout_odd` = 1. The following edge registers a direct output with `dout_odd` = 0. The two kinds strictly alternate.
- R4: The direct output registered on the edge after capture m equals the sample captured at capture m-11. Captures before the first one count as 0x2000.
- R5: Let s(i) be capture i minus 0x2000, with s(i) = 0 for i < 0. The interpolated output registered at capture m is y = floor((A + 2^14) / 2^15) + 0x2000, where A = sum over k = 1..11 of c(k) * (s(m-12+k) + s(m-11-k)). The coefficients c(1..11) are 20766, -6762, 3858, -2490, 1686, -1150, 768, -486, 282, -142, 54.
- R6: Before 0x2000 is added back, the rounded interpolated value is clamped to the range -8192..8191. The output therefore stays within 0..16383.
- R7: When the latched mode is 1, the interpolated output becomes 0x2000 - v, where v is the clamped signed value of R6. A result of 0x4000 is clamped to 16383. Direct outputs are never altered.
- R8: `hp_mode` is sampled only at edges that register a direct output. The interpolated output of the same pair, registered at the next capture, uses that sampled value. `hp_mode` in any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 14 | Input sample, straight binary |
| hp_mode | input | 1 | 1 selects the high-pass (mixed) response |
| take_in | output | 1 | High in cycles whose closing edge captures `din` |
| dout | output | 14 | Output sample, straight binary |
| dout_odd | output | 1 | 1 when `dout` holds an interpolated sample |

## Verification
The checker watches the cycle-level protocol on every cycle: the alternation of the take strobe and of the output flag, an interpolated output on each capture edge, the mode staying frozen between the two samples of a pair, and midscale after reset. The numeric behaviour can only be shown by the bench scenarios: the eleven-capture delay of direct samples, the coefficient sum with its rounding, clamping at both rails, and the mirror about midscale. The bench drives impulses, DC at both rails, random full-scale extremes and random mode toggling inside pairs, and compares each result with the formulas above.

// File: rtl/hb2x_pkg.sv
package hb2x_pkg;
  localparam int HB_SIDE   = 11;   // folded coefficient pairs
  localparam int HB_COEF_W = 16;   // signed coefficient width
  localparam int HB_FRAC   = 15;   // coefficient scale 2^15

  typedef enum logic {PH_TAKE = 1'b0, PH_HOLD = 1'b1} hb_phase_e;

  // Folded half-band coefficients, k = 1 nearest the centre.
  function automatic logic signed [HB_COEF_W-1:0] hb_coef(input int k);
    case (k)
      1:  return 16'sd20766;
      2:  return -16'sd6762;
      3:  return 16'sd3858;
      4:  return -16'sd2490;
      5:  return 16'sd1686;
      6:  return -16'sd1150;
      7:  return 16'sd768;
      8:  return -16'sd486;
      9:  return 16'sd282;
      10: return -16'sd142;
      11: return 16'sd54;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hb2x_phase.sv
module hb2x_phase
  import hb2x_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hp_mode,
  output logic take_in,
  output logic mode_lat
);
  hb_phase_e ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_TAKE;
      mode_lat <= 1'b0;
    end else begin
      ph <= (ph == PH_TAKE) ? PH_HOLD : PH_TAKE;
      // mode is sampled only when a direct sample is registered
      if (ph == PH_HOLD) mode_lat <= hp_mode;
    end
  end

  assign take_in = (ph == PH_TAKE);
endmodule

// File: rtl/hb2x_taps.sv
module hb2x_taps #(
  parameter int DW    = 14,
  parameter int DEPTH = 22
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift_en,
  input  logic [DW-1:0]             din_s,
  output logic [DEPTH-1:0][DW-1:0]  taps
);
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)           taps[i] <= '0;
        else if (shift_en) taps[i] <= (i == 0) ? din_s : taps[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/hb2x_odd_mac.sv
module hb2x_odd_mac
  import hb2x_pkg::*;
#(
  parameter int DW     = 14,
  parameter int SIDE_N = HB_SIDE
) (
  input  logic [2*SIDE_N-1:0][DW-1:0] taps,
  output logic signed [DW-1:0]        y,
  output logic                        clip
);
  localparam int CW = HB_COEF_W;
  localparam int AW = DW + 1 + CW + $clog2(SIDE_N) + 1;
  localparam logic signed [AW-1:0] HALF_LSB = AW'(1) <<< (HB_FRAC - 1);
  localparam logic signed [AW-1:0] Y_MAX = AW'((1 << (DW-1)) - 1);
  localparam logic signed [AW-1:0] Y_MIN = -AW'(1 << (DW-1));

  logic signed [AW-1:0] prod [SIDE_N];
  logic signed [AW-1:0] acc;

  generate
    for (genvar k = 1; k <= SIDE_N; k++) begin : g_fold
      logic signed [DW:0] near_s, far_s, pair_sum;
      assign near_s   = {taps[SIDE_N-k][DW-1], taps[SIDE_N-k]};
      assign far_s    = {taps[SIDE_N-1+k][DW-1], taps[SIDE_N-1+k]};
      assign pair_sum = near_s + far_s;
      assign prod[k-1] = AW'(pair_sum) * AW'(hb_coef(k));
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < SIDE_N; i++) acc = acc + prod[i];
  end

  // round half up, then clamp to the signed data range
  function automatic logic signed [DW:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    r = (a + HALF_LSB) >>> HB_FRAC;
    if (r > Y_MAX)      return {1'b1, Y_MAX[DW-1:0]};
    else if (r < Y_MIN) return {1'b1, Y_MIN[DW-1:0]};
    else                return {1'b0, r[DW-1:0]};
  endfunction

  logic [DW:0] rs;
  assign rs   = round_sat(acc);
  assign y    = rs[DW-1:0];
  assign clip = rs[DW];
endmodule

// File: rtl/hb2x_interp.sv
module hb2x_interp
  import hb2x_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          hp_mode,
  output logic          take_in,
  output logic [DW-1:0] dout,
  output logic          dout_odd
);
  localparam int DEPTH = 2 * HB_SIDE;
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);
  localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

  logic                      mode_lat;
  logic [DEPTH-1:0][DW-1:0]  taps;
  logic signed [DW-1:0]      odd_y;
  logic                      odd_clip;
  logic [DW-1:0]             even_out, odd_out;

  // negate about zero, the one unrepresentable result clamps
  function automatic logic signed [DW-1:0] mirror(input logic signed [DW-1:0] v);
    return (v == S_MIN) ? S_MAX : -v;
  endfunction

  hb2x_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .hp_mode  (hp_mode),
    .take_in  (take_in),
    .mode_lat (mode_lat)
  );

  // straight binary to two's complement: invert the top bit
  hb2x_taps #(.DW(DW), .DEPTH(DEPTH)) u_taps (
    .clk      (clk),
    .rst      (rst),
    .shift_en (take_in),
    .din_s    (din ^ MID),
    .taps     (taps)
  );

  hb2x_odd_mac #(.DW(DW), .SIDE_N(HB_SIDE)) u_mac (
    .taps (taps),
    .y    (odd_y),
    .clip (odd_clip)
  );

  assign even_out = taps[HB_SIDE] ^ MID;
  assign odd_out  = (mode_lat ? mirror(odd_y) : odd_y) ^ MID;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= MID;
      dout_odd <= 1'b0;
    end else if (take_in) begin
      dout     <= odd_out;
      dout_odd <= 1'b1;
    end else begin
      dout     <= even_out;
      dout_odd <= 1'b0;
    end
  end
endmodule

// File: rtl/hb2x_interp_chk.sv
module hb2x_interp_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          take_in,
  input logic [DW-1:0] dout,
  input logic          dout_odd,
  input logic          mode_lat
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);

  assert_reset_mid_R1: assert property (@(posedge clk)
    rst |=> (dout == MID) && !dout_odd && take_in);

  assert_take_alt_R2: assert property (@(posedge clk) disable iff (rst)
    take_in |=> !take_in);

  assert_take_return_R2: assert property (@(posedge clk) disable iff (rst)
    !take_in |=> take_in);

  assert_odd_on_take_R3: assert property (@(posedge clk) disable iff (rst)
    take_in |=> dout_odd);

  assert_flag_alt_R3: assert property (@(posedge clk) disable iff (rst)
    dout_odd |=> !dout_odd);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    dout_odd |-> $stable(mode_lat));
endmodule

bind hb2x_interp hb2x_interp_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .take_in  (take_in),
  .dout     (dout),
  .dout_odd (dout_odd),
  .mode_lat (mode_lat)
);

// File: tb/hb2x_interp_tb.sv
module hb2x_interp_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] din;
  logic        hp_mode;
  logic        take_in;
  logic [13:0] dout;
  logic        dout_odd;

  always #5 clk = ~clk;

  hb2x_interp u_dut (
    .clk(clk), .rst(rst), .din(din), .hp_mode(hp_mode),
    .take_in(take_in), .dout(dout), .dout_odd(dout_odd)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int hist [0:4095];
  int takes    = 0;
  bit bmode    = 1'b0;
  int n_clip   = 0;
  int coef [11] = '{20766, -6762, 3858, -2490, 1686, -1150, 768, -486, 282, -142, 54};

  function automatic int s_at(int i);
    return (i < 0) ? 0 : hist[i];
  endfunction

  function automatic int clampv(int v);
    if (v > 8191)  return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  // interpolated output for capture m, straight from R5..R7
  function automatic int odd_expect(int m, bit md, output bit clipped);
    longint a = 0;
    longint r;
    int v;
    for (int k = 1; k <= 11; k++)
      a += longint'(coef[k-1]) * longint'(s_at(m-12+k) + s_at(m-11-k));
    r = (a + 64'sd16384) >>> 15;
    clipped = (r > 8191) || (r < -8192);
    v = clampv(int'(r));
    if (md) v = clampv(-v);
    return v + 8192;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one input period: capture edge then direct-sample edge
  task automatic pair(int v, bit hp_a, bit hp_b);
    int  e;
    bit  clipped;
    check("R2 take_in high", int'(take_in), 1);
    din = v[13:0];
    hp_mode = hp_a;
    @(posedge clk);
    hist[takes] = v - 8192;
    @(negedge clk);
    e = odd_expect(takes, bmode, clipped);
    if (clipped) n_clip++;
    check("R3 odd flag", int'(dout_odd), 1);
    check($sformatf("%s interpolated sample", clipped ? "R6" :
          (bmode ? "R7" : (hp_a != bmode ? "R8" : "R5"))), int'(dout), e);
    takes++;
    check("R2 take_in low", int'(take_in), 0);
    din = 14'($urandom);      // R2: must be ignored
    hp_mode = hp_b;
    @(negedge clk);
    bmode = hp_b;             // R8: sampled at the direct-sample edge
    check("R3 direct flag", int'(dout_odd), 0);
    check("R4 direct sample", int'(dout), s_at(takes - 1 - 11) + 8192);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; din = 14'h2000; hp_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset dout", int'(dout), 8192);
    check("R1 reset flag", int'(dout_odd), 0);
    check("R1 reset take_in", int'(take_in), 1);

    // R4: impulse shows the eleven-capture delay and the R5 kernel
    pair(16383, 0, 0);
    for (int i = 0; i < 30; i++) pair(8192, 0, 0);
    // DC at the low rail, low-pass then high-pass (R7 gives 16383)
    for (int i = 0; i < 30; i++) pair(0, 0, 0);
    for (int i = 0; i < 15; i++) pair(0, 1, 1);
    // DC at the high rail
    for (int i = 0; i < 30; i++) pair(16383, 1, 0);
    // extremes drive clipping (R6), modes toggled inside pairs (R8)
    for (int i = 0; i < 200; i++)
      pair(($urandom % 2) ? 16383 : 0, 1'($urandom), 1'($urandom));
    // R8: hp_mode toggled only in capture cycles must not take effect
    for (int i = 0; i < 20; i++) pair(int'($urandom % 16384), 1, 0);
    // general random
    for (int i = 0; i < 300; i++)
      pair(int'($urandom % 16384), 1'($urandom), 1'($urandom));

    check("R6 clipping was exercised", int'(n_clip > 0), 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule